// File: doc/BRIEF.md
# Hold-Until-Release Round Robin Arbiter

This block shares a single resource among `N` requesters. Each requester raises its own request line and receives its own grant line. At most one grant line is high at a time. A requester that wins keeps the grant for as long as it holds its request high, so a transaction in progress is never taken away.

When the holder drops its request, the arbiter hands the grant straight on to the next requester that is asking. It searches in cyclic order, starting just after the old holder. There is no idle cycle between holders, and a requester that keeps asking is always reached. The grant comes from a register, so grant changes appear one clock after the request pattern that caused them. The block has one clock and an active-low asynchronous reset.

Top module: `rr_hold_arb`

## Requirements
- R1: While `rst_ni` is low, `gnt_o` is all zero. After reset, requester 0 has the highest priority, so the first grant goes to the lowest-numbered active request.
- R2: At most one bit of `gnt_o` is high in any cycle.
- R3: If the current holder's request is high at a clock edge, `gnt_o` is unchanged after that edge, whatever the other requests are.
- R4: If the holder's request is low at an edge and another request is high, the grant moves at that same edge to the first active requester after the holder in cyclic order (index + 1, wrapping from N-1 to 0). No idle cycle is inserted.
- R5: If no request is high at an edge, `gnt_o` becomes zero. The last holder's position is kept, so the next search starts just after it.
- R6: A requester that holds its request high while other grants begin is granted before more than N other grants have started.
- R7: `gnt_o` is registered. A change on `req_i` reaches `gnt_o` only after the next rising clock edge. A grant bit is set only for a requester whose request was high at that edge.
- R8: If no grant is held and requests are present, the winner is the first active requester after the last holder, in cyclic order.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | N | Request lines, one per requester |
| gnt_o | output | N | Registered grant lines, one-hot or zero |

## Verification
Two functions can act at the same clock edge: releasing the lock and choosing a new winner. The holder drops its request while others are still asking, so the handover and the rotating search must both resolve at that edge.

Random stimulus provokes this case often. It drops the holder's request with higher probability than the others, and keeps other requests set. Directed cases place the release right at the wrap from N-1 to 0.

The result is judged against a bench model with two checks. The new grant must appear one cycle after the release, with no zero cycle in between. It must also land on the next active index after the old holder.

// File: rtl/rrh_pkg.sv
package rrh_pkg;
  function automatic int idx_w(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/rrh_ffs.sv
// lowest set bit finder
module rrh_ffs #(
  parameter int N  = 4,
  parameter int IW = 2
) (
  input  logic [N-1:0]  vec_i,
  output logic          found_o,
  output logic [IW-1:0] idx_o
);
  always_comb begin
    found_o = |vec_i;
    idx_o   = '0;
    for (int k = N - 1; k >= 0; k--) begin
      if (vec_i[k]) idx_o = IW'(k);
    end
  end
endmodule

// File: rtl/rrh_pick.sv
// cyclic search starting one past ptr_i: masked encoder, unmasked fallback
module rrh_pick #(
  parameter int N  = 4,
  parameter int IW = 2
) (
  input  logic [N-1:0]  req_i,
  input  logic [IW-1:0] ptr_i,
  output logic          found_o,
  output logic [IW-1:0] idx_o
);
  logic [N-1:0]  mask;
  logic          m_found, p_found;
  logic [IW-1:0] m_idx, p_idx;

  for (genvar g = 0; g < N; g++) begin : g_mask
    assign mask[g] = (IW'(g) > ptr_i);
  end

  rrh_ffs #(.N(N), .IW(IW)) u_masked (
    .vec_i(req_i & mask), .found_o(m_found), .idx_o(m_idx)
  );
  rrh_ffs #(.N(N), .IW(IW)) u_plain (
    .vec_i(req_i), .found_o(p_found), .idx_o(p_idx)
  );

  assign found_o = m_found | p_found;
  assign idx_o   = m_found ? m_idx : p_idx;
endmodule

// File: rtl/rr_hold_arb.sv
module rr_hold_arb #(
  parameter int N = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] req_i,
  output logic [N-1:0] gnt_o
);
  localparam int IW = rrh_pkg::idx_w(N);

  logic [N-1:0]  gnt_q, gnt_d;
  logic [IW-1:0] ptr_q, ptr_d;
  logic          hold, found;
  logic [IW-1:0] win_idx;

  assign hold = |(gnt_q & req_i);

  rrh_pick #(.N(N), .IW(IW)) u_pick (
    .req_i(req_i), .ptr_i(ptr_q), .found_o(found), .idx_o(win_idx)
  );

  always_comb begin
    gnt_d = gnt_q;
    ptr_d = ptr_q;
    if (!hold) begin
      gnt_d = '0;
      if (found) begin
        gnt_d[win_idx] = 1'b1;
        ptr_d          = win_idx;
      end
    end
  end

  // ptr holds the last winner; reset to N-1 so requester 0 is searched first
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gnt_q <= '0;
      ptr_q <= IW'(N - 1);
    end else begin
      gnt_q <= gnt_d;
      ptr_q <= ptr_d;
    end
  end

  assign gnt_o = gnt_q;
endmodule

// File: rtl/rr_hold_arb_chk.sv
module rr_hold_arb_chk #(
  parameter int N = 4
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic [N-1:0] req_i,
  input logic [N-1:0] gnt_o
);
  localparam int CW = $clog2(N + 2) + 1;

  logic [N-1:0] gnt_prev;
  logic         new_start;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) gnt_prev <= '0;
    else         gnt_prev <= gnt_o;
  end
  assign new_start = (gnt_o != '0) && (gnt_o != gnt_prev);

  AST_RESET_IDLE: assert property (@(posedge clk_i)
    !rst_ni |-> gnt_o == '0); // R1

  AST_GNT_ONEHOT0: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(gnt_o)); // R2

  AST_LOCK_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gnt_o & req_i) != '0 |=> gnt_o == $past(gnt_o)); // R3

  AST_NO_BUBBLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gnt_o != '0 && (gnt_o & req_i) == '0 && req_i != '0)
      |=> (gnt_o != '0 && (gnt_o & $past(gnt_o)) == '0)); // R4

  AST_IDLE_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i == '0 |=> gnt_o == '0); // R5

  AST_GNT_FROM_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gnt_o != '0 |=> (gnt_o == '0) || ((gnt_o & $past(req_i)) != '0)); // R7

  for (genvar i = 0; i < N; i++) begin : g_starve
    logic [CW-1:0] wait_cnt;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) wait_cnt <= '0;
      else if (!req_i[i] || gnt_o[i]) wait_cnt <= '0;
      else if (new_start && wait_cnt <= CW'(N)) wait_cnt <= wait_cnt + 1'b1;
    end
    AST_NO_STARVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      wait_cnt <= CW'(N)); // R6
  end
endmodule

bind rr_hold_arb rr_hold_arb_chk #(.N(N)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req_i), .gnt_o(gnt_o)
);

// File: tb/tb_rr_hold_arb.sv
`timescale 1ns/1ps
module tb_rr_hold_arb;
  localparam int N = 4;

  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic [N-1:0] req_i = '0;
  logic [N-1:0] gnt_o;

  int checks = 0, failures = 0;
  int m_gnt = -1;      // model holder, -1 none
  int m_ptr = N - 1;   // model last holder
  bit done = 0;
  int wait_cnt [N];
  logic [N-1:0] obs_prev = '0;

  always #2 clk_i = ~clk_i;

  rr_hold_arb #(.N(N)) dut (.clk_i(clk_i), .rst_ni(rst_ni), .req_i(req_i), .gnt_o(gnt_o));

  function automatic int pick(input logic [N-1:0] r, input int p);
    for (int off = 1; off <= N; off++) begin
      int k = (p + off) % N;
      if (r[k]) return k;
    end
    return -1;
  endfunction

  function automatic logic [N-1:0] to_vec(input int g);
    logic [N-1:0] v = '0;
    if (g >= 0) v[g] = 1'b1;
    return v;
  endfunction

  task automatic check(input string tag, input logic [N-1:0] act, input logic [N-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s gnt_o=%b expected=%b", tag, act, exp);
    end
  endtask

  // drive at negedge, update model at posedge, check at next negedge
  task automatic step(input logic [N-1:0] r);
    string tag;
    req_i = r;
    @(posedge clk_i);
    if (m_gnt >= 0 && r[m_gnt]) tag = "R3";
    else begin
      int w = pick(r, m_ptr);
      if (w < 0) begin tag = "R5"; m_gnt = -1; end
      else begin
        tag = (m_gnt >= 0) ? "R4" : "R8";
        m_gnt = w; m_ptr = w;
      end
    end
    @(negedge clk_i);
    check(tag, gnt_o, to_vec(m_gnt));
    if ($countones(gnt_o) > 1) check("R2", gnt_o, to_vec(m_gnt));
    // starvation tracking from observed grants
    for (int i = 0; i < N; i++) begin
      if (!r[i] || gnt_o[i]) wait_cnt[i] = 0;
      else if (gnt_o != '0 && gnt_o != obs_prev) wait_cnt[i]++;
      if (wait_cnt[i] > N) begin
        checks++; failures++;
        $display("FAIL R6 req %0d waited %0d grants expected<=%0d", i, wait_cnt[i], N);
        wait_cnt[i] = 0;
      end
    end
    obs_prev = gnt_o;
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    for (int i = 0; i < N; i++) wait_cnt[i] = 0;
    req_i = '1;
    repeat (3) @(negedge clk_i);
    check("R1 in reset", gnt_o, '0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    step(4'b1111);                 // R1: requester 0 first
    check("R1 first winner", gnt_o, 4'b0001);
    step(4'b1111);                 // R3 hold
    step(4'b1110);                 // R4 handover to 1
    check("R4 handover", gnt_o, 4'b0010);
    // R7: change on req_i not visible before the edge
    req_i = 4'b1000;
    #1;
    check("R7 registered", gnt_o, 4'b0010);
    @(negedge clk_i);
    m_gnt = 3; m_ptr = 3;
    check("R7 next edge", gnt_o, 4'b1000);
    step(4'b0010);                 // R4 wrap from 3 to 1
    check("R4 wrap", gnt_o, 4'b0010);
    step(4'b0000);                 // R5 idle
    check("R5 idle", gnt_o, 4'b0000);
    step(4'b0101);                 // R5 pointer kept at 1 -> 2 wins
    check("R5 ptr kept", gnt_o, 4'b0100);
    step(4'b0001);                 // R4 to 0
    step(4'b0011);                 // R3 lock held with others asking
    check("R3 lock", gnt_o, 4'b0001);
    step(4'b0000);
    step(4'b1010);                 // R8 from ptr 0 -> 1
    check("R8 search", gnt_o, 4'b0010);

    for (int c = 0; c < 4000; c++) begin
      logic [N-1:0] r = req_i;
      for (int i = 0; i < N; i++) begin
        if (i == m_gnt)  begin if ($urandom_range(3) == 0) r[i] = 1'b0; end
        else if (r[i])   begin if ($urandom_range(15) == 0) r[i] = 1'b0; end
        else             begin if ($urandom_range(3) == 0) r[i] = 1'b1; end
      end
      if ($urandom_range(49) == 0) r = '0;
      step(r);
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule